// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a two's-complement integer in a single combinational pass. The operand arrives already split into a class code, a sign, an unbiased exponent and a normalized mantissa whose top bit is the explicit leading one. A sticky bit carries precision that earlier stages have already dropped. The block returns the integer and two exception flags: one for an inexact result and one for an invalid conversion.

The conversion always truncates toward zero, and no rounding mode is consulted. A finite value whose integer part does not fit the result is invalid. So is an infinity, a NaN of either kind, or an unknown class code. In each invalid case the block returns a saturation value chosen by the sign, and the inexact flag is dropped in favour of the invalid flag. A single parameter selects a 32-bit or a 64-bit result.

The operand's value is mantissa × 2^(exponent − (MANT_W − 1)), where MANT_W is the mantissa width.

Top module: `fcvt_to_int`

## Requirements
- R1: The class code 0 means zero. For a zero, the result is 0 and both flags are low, whatever the sign, exponent, mantissa and sticky inputs hold.
- R2: The class codes are 0 zero, 1 finite number, 2 infinity, 3 quiet NaN and 4 signalling NaN. Codes 2 to 7 all give an invalid conversion.
- R3: For class 1, the result magnitude is the integer part of mantissa × 2^(exponent − (MANT_W − 1)), truncated toward zero. No rounding increment is ever added.
- R4: A valid result raises the inexact flag when the shift drops any nonzero mantissa bit, or when the sticky input is 1. Otherwise the inexact flag is low.
- R5: A class 1 operand whose signed exponent is at least the result width W is an invalid conversion.
- R6: The largest accepted positive magnitude is 2^(W−1) − 1. A negative operand also accepts the magnitude 2^(W−1). Any larger magnitude is an invalid conversion.
- R7: On an invalid conversion, the invalid flag is high and the inexact flag is low. The result is 2^(W−1) − 1 for sign 0 and 2^(W−1), the most negative value, for sign 1.
- R8: A negative exponent of any size yields 0, with inexact set whenever the mantissa or the sticky input is nonzero. The shift amount never wraps around.
- R9: The parameter WIDE = 0 gives a 32-bit result and WIDE = 1 gives a 64-bit result. The range rules apply at the selected width.
- R10: A valid result with sign 1 is the two's-complement negation of the magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_i | input | 3 | Operand class code (see R2) |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W | Unbiased exponent, two's complement |
| mant_i | input | MANT_W | Mantissa with the explicit leading one in the top bit |
| sticky_i | input | 1 | Precision already lost upstream |
| result_o | output | W (32 or 64) | Converted integer |
| invalid_o | output | 1 | Invalid conversion: overflow, infinity or NaN |
| inexact_o | output | 1 | A valid result dropped fraction bits |

## Verification
Exact integers separate correct alignment from an off-by-one shift. Values with fractions, of both signs, show that truncation moves toward zero and that inexact follows the lost bits. A sticky-only case shows that upstream precision loss alone raises inexact. Operands at ±2^(W−1), one step either side of it, and at exponents W−1 and W separate the asymmetric limit from a symmetric one. These cases run against a 32-bit and a 64-bit instance, so one operand passes in one width and saturates in the other. Very negative exponents catch a wrapping shift, and the non-number class codes together with random finite operands cover the saturation and sign handling.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NUM  = 3'd1,
    FC_INF  = 3'd2,
    FC_QNAN = 3'd3,
    FC_SNAN = 3'd4
  } fclass_e;

  // Any code other than zero or number converts as invalid.
  function automatic logic class_is_special(input logic [2:0] c);
    return (c != FC_ZERO) && (c != FC_NUM);
  endfunction

endpackage

// File: rtl/fcvt_align.sv
// Moves the integer part of the mantissa into the low bits and reports lost bits.
module fcvt_align #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16,
  parameter int OUT_W  = 32
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  output logic [OUT_W-1:0]  mag_o,
  output logic              inexact_o,
  output logic              big_exp_o
);
  localparam int SH_W = $clog2(MANT_W + 1);
  localparam logic signed [EXP_W+1:0] TOP_IDX = (EXP_W+2)'(MANT_W - 1);
  localparam logic signed [EXP_W+1:0] MANT_X  = (EXP_W+2)'(MANT_W);
  localparam logic signed [EXP_W+1:0] OUT_X   = (EXP_W+2)'(OUT_W);

  logic signed [EXP_W+1:0] exp_x;
  logic signed [EXP_W+1:0] amt_full;
  logic [SH_W-1:0]         amt;
  logic                    lost_nz;

  // Clamp the right-shift distance to the range 0 to MANT_W.
  function automatic logic [SH_W-1:0] sat_amt(input logic signed [EXP_W+1:0] a);
    if (a < 0)            return '0;
    else if (a > MANT_X)  return SH_W'(MANT_W);
    else                  return SH_W'(a);
  endfunction

  function automatic logic [MANT_W-1:0] shr(input logic [MANT_W-1:0] m,
                                            input logic [SH_W-1:0] s);
    return m >> s;
  endfunction

  function automatic logic dropped(input logic [MANT_W-1:0] m,
                                   input logic [SH_W-1:0] s);
    return |(m & ~({MANT_W{1'b1}} << s));
  endfunction

  assign exp_x     = {{2{exp_i[EXP_W-1]}}, exp_i};
  assign amt_full  = TOP_IDX - exp_x;
  assign amt       = sat_amt(amt_full);
  assign big_exp_o = (exp_x >= OUT_X);
  assign mag_o     = OUT_W'(shr(mant_i, amt));
  assign lost_nz   = dropped(mant_i, amt);
  assign inexact_o = lost_nz | sticky_i;

  always_comb begin
    // R8: a negative exponent leaves no integer bits
    a_r8_no_wrap: assert (!(exp_x < 0) || (mag_o == '0))
      else $error("negative exponent produced nonzero magnitude");
  end

endmodule

// File: rtl/fcvt_limit.sv
// Range check against the sign-dependent limit and choice of the saturation value.
module fcvt_limit #(
  parameter int OUT_W = 32
) (
  input  logic [OUT_W-1:0] mag_i,
  input  logic             neg_i,
  output logic             too_big_o,
  output logic [OUT_W-1:0] sat_o
);
  localparam logic [OUT_W-1:0] MAXPOS = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] limit;

  assign limit     = MAXPOS + OUT_W'(neg_i);
  assign too_big_o = (mag_i > limit);
  assign sat_o     = limit;

  always_comb begin
    // R6: an out-of-range magnitude always has its top bit set
    a_r6_limit_floor: assert (!too_big_o || mag_i[OUT_W-1])
      else $error("range flagged below 2^(W-1)");
  end

endmodule

// File: rtl/fcvt_to_int.sv
module fcvt_to_int
  import fcvt_pkg::*;
#(
  parameter bit WIDE   = 1'b0,
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16,
  localparam int OUT_W = WIDE ? 64 : 32
) (
  input  logic [2:0]        cls_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  output logic [OUT_W-1:0]  result_o,
  output logic              invalid_o,
  output logic              inexact_o
);
  localparam logic [OUT_W-1:0] MAXPOS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINNEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] mag;
  logic             lost_any;
  logic             big_exp;
  logic             too_big;
  logic [OUT_W-1:0] sat_val;
  logic             is_num;
  logic             is_zero;
  logic             valid_num;
  logic [OUT_W-1:0] signed_mag;

  fcvt_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_align (
    .exp_i     (exp_i),
    .mant_i    (mant_i),
    .sticky_i  (sticky_i),
    .mag_o     (mag),
    .inexact_o (lost_any),
    .big_exp_o (big_exp)
  );

  fcvt_limit #(.OUT_W(OUT_W)) u_limit (
    .mag_i     (mag),
    .neg_i     (sign_i),
    .too_big_o (too_big),
    .sat_o     (sat_val)
  );

  function automatic logic [OUT_W-1:0] apply_sign(input logic [OUT_W-1:0] m,
                                                   input logic n);
    return n ? (~m + {{(OUT_W-1){1'b0}}, 1'b1}) : m;
  endfunction

  assign is_num     = (cls_i == FC_NUM);
  assign is_zero    = (cls_i == FC_ZERO);
  assign valid_num  = is_num && !big_exp && !too_big;
  assign signed_mag = apply_sign(mag, sign_i);

  always_comb begin
    result_o  = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (valid_num) begin
      result_o  = signed_mag;
      inexact_o = lost_any;
    end else if (!is_zero) begin
      result_o  = sat_val;
      invalid_o = 1'b1;
    end
  end

  always_comb begin
    // R1: zero class is silent
    a_r1_zero_clean: assert (!is_zero || (result_o == '0 && !invalid_o && !inexact_o))
      else $error("zero class produced output");
    // R7: invalid result is the signed saturation value
    a_r7_sat_value: assert (!invalid_o || (result_o == (sign_i ? MINNEG : MAXPOS)))
      else $error("wrong saturation value");
    // R7: inexact never accompanies invalid
    a_r7_flags_exclusive: assert (!(invalid_o && inexact_o))
      else $error("inexact with invalid");
    // R2: special classes are always invalid
    a_r2_special_invalid: assert (!class_is_special(cls_i) || invalid_o)
      else $error("special class not invalid");
    // R6: a valid positive result stays nonnegative
    a_r6_pos_range: assert (!(valid_num && !sign_i) || !result_o[OUT_W-1])
      else $error("positive result wrapped");
    // R10: a valid negative result is zero or negative
    a_r10_neg_sign: assert (!(valid_num && sign_i) || result_o == '0 || result_o[OUT_W-1])
      else $error("negative result has wrong sign");
  end

endmodule

// File: tb/tb_fcvt_to_int.sv
module tb_fcvt_to_int;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0]  cls;
  logic        sgn;
  logic [15:0] ex;
  logic [63:0] mt;
  logic        st;
  logic [31:0] r32;
  logic        inv32, inx32;
  logic [63:0] r64;
  logic        inv64, inx64;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  fcvt_to_int #(.WIDE(1'b0)) dut (
    .cls_i(cls), .sign_i(sgn), .exp_i(ex), .mant_i(mt), .sticky_i(st),
    .result_o(r32), .invalid_o(inv32), .inexact_o(inx32));

  fcvt_to_int #(.WIDE(1'b1)) dut64 (
    .cls_i(cls), .sign_i(sgn), .exp_i(ex), .mant_i(mt), .sticky_i(st),
    .result_o(r64), .invalid_o(inv64), .inexact_o(inx64));

  // Behavioural model: bit-by-bit weighting of the mantissa.
  task automatic model(input int w, input logic [2:0] c, input logic s, input int e,
                       input logic [63:0] m, input logic sk,
                       output logic [63:0] r, output logic iv, output logic ix);
    logic [127:0] acc;
    logic [127:0] lim;
    logic lost;
    logic [63:0] wmask;
    wmask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    r = 0; iv = 0; ix = 0;
    if (c == 3'd0) return;
    acc = 0; lost = sk;
    if (c == 3'd1 && e < w) begin
      for (int i = 0; i < 64; i++) begin
        if (m[i]) begin
          int wt;
          wt = e - (63 - i);
          if (wt >= 0) acc[wt] = 1'b1;
          else lost = 1'b1;
        end
      end
      lim = (128'd1 << (w - 1)) - 128'd1 + {127'd0, s};
      if (acc <= lim) begin
        r  = (s ? (~acc[63:0] + 64'd1) : acc[63:0]) & wmask;
        ix = lost;
        return;
      end
    end
    iv = 1;
    r  = s ? (64'd1 << (w - 1)) : ((64'd1 << (w - 1)) - 64'd1);
  endtask

  task automatic apply(input string tag, input logic [2:0] c, input logic s, input int e,
                       input logic [63:0] m, input logic sk);
    logic [63:0] er; logic ei, ex_;
    @(posedge clk);
    cls = c; sgn = s; ex = 16'(e); mt = m; st = sk;
    @(negedge clk);
    model(32, c, s, e, m, sk, er, ei, ex_);
    checks++;
    if ({32'd0, r32} !== er || inv32 !== ei || inx32 !== ex_) begin
      errors++;
      $display("FAIL %s w32: got r=%h inv=%b inx=%b expected r=%h inv=%b inx=%b",
               tag, r32, inv32, inx32, er[31:0], ei, ex_);
    end
    model(64, c, s, e, m, sk, er, ei, ex_);
    checks++;
    if (r64 !== er || inv64 !== ei || inx64 !== ex_) begin
      errors++;
      $display("FAIL %s w64: got r=%h inv=%b inx=%b expected r=%h inv=%b inx=%b",
               tag, r64, inv64, inx64, er, ei, ex_);
    end
  endtask

  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  initial begin
    cls = 3'd0; sgn = 0; ex = 0; mt = 0; st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (r32 !== 0 || inv32 || inx32 || r64 !== 0 || inv64 || inx64) begin
      errors++;
      $display("FAIL R1 reset: got r32=%h r64=%h expected 0", r32, r64);
    end
    rst = 1'b0;
    apply("R1", 3'd0, 1, 40, ONE | 64'd5, 1);
    apply("R3", 3'd1, 0, 0, ONE, 0);                    // 1.0
    apply("R4", 3'd1, 0, 0, 64'hC000_0000_0000_0000, 0); // 1.5
    apply("R10", 3'd1, 1, 1, 64'hB000_0000_0000_0000, 0); // -2.75
    apply("R4", 3'd1, 0, 6, 64'hC800_0000_0000_0000, 1); // 100 with sticky
    apply("R3", 3'd1, 1, 6, 64'hC800_0000_0000_0000, 0); // -100 exact
    apply("R8", 3'd1, 0, -1, ONE, 0);
    apply("R8", 3'd1, 1, -200, ONE, 0);
    apply("R8", 3'd1, 0, -32768, ONE, 0);
    apply("R6", 3'd1, 0, 31, ONE, 0);                   // +2^31
    apply("R6", 3'd1, 1, 31, ONE, 0);                   // -2^31
    apply("R6", 3'd1, 1, 31, ONE | 64'h0000_0000_8000_0000, 0); // -(2^31+0.5)
    apply("R6", 3'd1, 1, 31, ONE | 64'h0000_0001_0000_0000, 0); // -(2^31+1)
    apply("R6", 3'd1, 0, 30, 64'hFFFF_FFFF_FFFF_FFFF, 0); // just under 2^31
    apply("R5", 3'd1, 0, 32, ONE, 0);
    apply("R9", 3'd1, 1, 40, ONE | 64'd1, 0);
    apply("R9", 3'd1, 1, 63, ONE, 0);                   // -2^63
    apply("R9", 3'd1, 0, 63, ONE, 0);                   // +2^63
    apply("R5", 3'd1, 0, 64, ONE, 1);
    apply("R7", 3'd1, 1, 300, ONE, 1);
    apply("R2", 3'd2, 0, 0, ONE, 0);
    apply("R2", 3'd2, 1, 0, ONE, 1);
    apply("R2", 3'd3, 0, 5, ONE, 0);
    apply("R2", 3'd4, 1, 5, ONE, 0);
    apply("R2", 3'd7, 0, 0, 64'd0, 0);
    for (int k = 0; k < 40; k++) begin
      apply("R3", 3'd1, 1'($urandom), int'($urandom_range(0, 74)) - 4,
            ONE | {$urandom, $urandom}, 1'($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule